// File: doc/BRIEF.md
# Counted Step Pulse Generator

This block produces a burst of step pulses for a stepper motor driver stage. When its run enable goes high, it takes a snapshot of the requested pulse count and gap setting. It then emits exactly that many square pulses on one output and stops. Timing does not come from the clock. It comes from an external single-cycle tick strobe, so an upstream rate divider sets the absolute step rate.

Each pulse stays high for `gapLen + 1` ticks and then low for `gapLen + 1` ticks. After the last low phase the generator parks with its output low. It starts a new burst only after the enable has been dropped and raised again. Dropping the enable at any point abandons the burst, and the output returns low on the next clock.

Top module: `stepgen`

## Requirements
- R1: While `rst` is high, `stepOut` is low, whatever the other inputs do. An assertion of `rst` forces it low without waiting for a clock.
- R2: With `runEn` held high, a snapshotted count of N gives exactly N rising and N falling edges on `stepOut`, for every N from 0 to 2^COUNT_W-1 (plain unsigned binary).
- R3: A snapshotted count of 0 gives no pulse for any gap value.
- R4: `stepOut` changes level only on clock edges where `tick` is high, or where `runEn` is low. With no ticks, the output holds its level indefinitely.
- R5: Each pulse is high for exactly G+1 ticks and then low for exactly G+1 ticks, where G is the snapshotted gap (unsigned binary). With count 7 and gap 7, the first 35 ticks therefore hold 3 rising and 2 falling edges.
- R6: The first rising edge happens on the first tick edge strictly after the clock edge that sampled `runEn` high while idle.
- R7: A clock edge that samples `runEn` low ends any burst, and `stepOut` is low after that edge.
- R8: `pulseCount` and `gapLen` are captured only at the edge that starts a burst. Changes to them during the burst have no effect on the output.
- R9: After the final low phase, `stepOut` stays low while `runEn` stays high, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| runEn | input | 1 | Run enable; a rising level starts a burst, low aborts |
| tick | input | 1 | Single-cycle advance strobe pacing all timing |
| pulseCount | input | COUNT_W | Number of pulses in the burst |
| gapLen | input | DELAY_W | Phase length minus one, in ticks |
| stepOut | output | 1 | Step pulse output |

## Verification
The assertions assume that `runEn` and `tick` are synchronous to `clk` and settle between edges. They also assume that a burst starts only from a low enable seen on the previous edge, so the checker can snapshot the count at the same edge the design does. The bench drives every input on the falling clock edge. Between bursts it always holds `runEn` low for at least one rising edge. The tick pattern may vary freely (every clock, every third or fourth clock, or muted for long stretches), and expectations are counted against the ticks actually delivered.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARMED,
    PH_HIGH,
    PH_LOW,
    PH_DONE
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // snapshot count and gap
    logic fire;    // start a pulse: reload timer, consume one pulse
    logic reload;  // reload timer for the low phase
    logic dec;     // count timer down
  } dpCmd_t;

endpackage

// File: rtl/stepgen_dp.sv
module stepgen_dp
  import stepgen_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int DELAY_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCmd_t             cmd,
  input  logic [COUNT_W-1:0] countIn,
  input  logic [DELAY_W-1:0] delayIn,
  output logic               timerZero,
  output logic               remZero,
  output logic               countInZero
);

  logic [COUNT_W-1:0] remCnt;
  logic [DELAY_W-1:0] gapReg;
  logic [DELAY_W-1:0] phaseTimer;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      remCnt     <= '0;
      gapReg     <= '0;
      phaseTimer <= '0;
    end else begin
      if (cmd.load) begin
        remCnt <= countIn;
        gapReg <= delayIn;
      end else if (cmd.fire) begin
        remCnt <= remCnt - COUNT_W'(1);
      end

      if (cmd.fire || cmd.reload) begin
        phaseTimer <= gapReg;
      end else if (cmd.dec) begin
        phaseTimer <= phaseTimer - DELAY_W'(1);
      end
    end
  end

  assign timerZero   = (phaseTimer == '0);
  assign remZero     = (remCnt == '0);
  assign countInZero = (countIn == '0);

endmodule

// File: rtl/stepgen_ctrl.sv
module stepgen_ctrl
  import stepgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   runEn,
  input  logic   tick,
  input  logic   timerZero,
  input  logic   remZero,
  input  logic   countInZero,
  output dpCmd_t cmd,
  output logic   stepOut
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    cmd       = '0;
    phaseNext = phase;
    if (!runEn) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cmd.load  = 1'b1;
          phaseNext = countInZero ? PH_DONE : PH_ARMED;
        end
        PH_ARMED: begin
          if (tick) begin
            cmd.fire  = 1'b1;
            phaseNext = PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            if (timerZero) begin
              cmd.reload = 1'b1;
              phaseNext  = PH_LOW;
            end else begin
              cmd.dec = 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (tick) begin
            if (!timerZero) begin
              cmd.dec = 1'b1;
            end else if (remZero) begin
              phaseNext = PH_DONE;
            end else begin
              cmd.fire  = 1'b1;
              phaseNext = PH_HIGH;
            end
          end
        end
        PH_DONE: phaseNext = PH_DONE;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  assign stepOut = (phase == PH_HIGH);

endmodule

// File: rtl/stepgen.sv
module stepgen
  import stepgen_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int DELAY_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               runEn,
  input  logic               tick,
  input  logic [COUNT_W-1:0] pulseCount,
  input  logic [DELAY_W-1:0] gapLen,
  output logic               stepOut
);

  dpCmd_t cmd;
  logic   timerZero;
  logic   remZero;
  logic   countInZero;

  stepgen_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .runEn       (runEn),
    .tick        (tick),
    .timerZero   (timerZero),
    .remZero     (remZero),
    .countInZero (countInZero),
    .cmd         (cmd),
    .stepOut     (stepOut)
  );

  stepgen_dp #(
    .COUNT_W (COUNT_W),
    .DELAY_W (DELAY_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd),
    .countIn     (pulseCount),
    .delayIn     (gapLen),
    .timerZero   (timerZero),
    .remZero     (remZero),
    .countInZero (countInZero)
  );

endmodule

// File: rtl/stepgen_checker.sv
module stepgen_checker #(
  parameter int COUNT_W = 4,
  parameter int DELAY_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               runEn,
  input logic               tick,
  input logic [COUNT_W-1:0] pulseCount,
  input logic               stepOut
);

  localparam int RW = COUNT_W + 1;

  logic               prevEn;
  logic               prevStep;
  logic [COUNT_W-1:0] capCount;
  logic [RW-1:0]      risesSeen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prevEn    <= 1'b0;
      prevStep  <= 1'b0;
      capCount  <= '0;
      risesSeen <= '0;
    end else begin
      prevEn   <= runEn;
      prevStep <= stepOut;
      if (runEn && !prevEn) begin
        capCount  <= pulseCount;
        risesSeen <= '0;
      end else if (stepOut && !prevStep) begin
        risesSeen <= risesSeen + RW'(1);
      end
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) rst |-> !stepOut);

  assert_abort_low_R7: assert property (@(posedge clk) disable iff (rst)
    !runEn |=> !stepOut);

  assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stepOut) |-> $past(tick));

  assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(stepOut) |-> ($past(tick) || !$past(runEn)));

  // R2 and R3: no rising edge beyond the snapshotted budget
  assert_pulse_budget_R2: assert property (@(posedge clk) disable iff (rst)
    (stepOut && !prevStep) |-> (risesSeen < {1'b0, capCount}));

endmodule

bind stepgen stepgen_checker #(
  .COUNT_W (COUNT_W),
  .DELAY_W (DELAY_W)
) u_chk (.*);

// File: tb/stepgen_test.sv
module stepgen_test;

  localparam int CW = 3;
  localparam int DW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          runEn = 1'b0;
  logic          tick = 1'b0;
  logic [CW-1:0] pulseCount = '0;
  logic [DW-1:0] gapLen = '0;
  logic          stepOut;

  int nChecks = 0;
  int nFail = 0;
  int tickCnt = 0;
  int tickPeriod = 4;
  bit tickMute = 1'b0;

  stepgen #(.COUNT_W(CW), .DELAY_W(DW)) uut (
    .clk(clk), .rst(rst), .runEn(runEn), .tick(tick),
    .pulseCount(pulseCount), .gapLen(gapLen), .stepOut(stepOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (tickCnt >= tickPeriod - 1) tickCnt <= 0;
    else tickCnt <= tickCnt + 1;
    tick <= (tickCnt >= tickPeriod - 1) && !tickMute;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // one full burst with waveform, edge-count and parking checks
  task automatic runBurst(input int n, input int d, input bit swapMid, input int muteAt);
    int  period = 2 * (d + 1);
    int  limit = n * period;
    int  k = 0;
    int  rises = 0;
    int  falls = 0;
    int  bad = 0;
    int  badAct = 0;
    int  badExp = 0;
    int  muteLeft = 0;
    bit  muteDone = 0;
    bit  muteHeld = 1;
    bit  exp;
    bit  t;
    bit  parked;
    logic prev = 1'b0;
    logic muteLevel = 1'b0;
    @(negedge clk);
    pulseCount = CW'(n);
    gapLen = DW'(d);
    runEn = 1'b1;
    @(negedge clk);
    while (k < limit + 6) begin
      t = tick;
      @(negedge clk);
      if (t) k++;
      exp = (k > 0) && ((k - 1) < limit) && (((k - 1) % period) < d + 1);
      if (stepOut !== exp) begin
        if (bad == 0) begin badAct = int'(stepOut); badExp = int'(exp); end
        bad++;
      end
      if (stepOut && !prev) rises++;
      if (!stepOut && prev) falls++;
      prev = stepOut;
      if (swapMid && k == 2) begin
        pulseCount = ~CW'(n);
        gapLen = ~DW'(d);
      end
      if (muteLeft > 0) begin
        if (stepOut !== muteLevel) muteHeld = 0;
        muteLeft--;
        if (muteLeft == 0) tickMute = 1'b0;
      end
      if (muteAt > 0 && k == muteAt && !muteDone) begin
        muteDone = 1;
        tickMute = 1'b1;
        muteLeft = 40;
        muteLevel = stepOut;
      end
    end
    check(bad == 0, swapMid ? "R8 waveform after mid-burst input change" : "R5 R6 waveform", badAct, badExp);
    check(rises == n, (n == 0) ? "R3 rising edges" : "R2 rising edges", rises, n);
    check(falls == n, (n == 0) ? "R3 falling edges" : "R2 falling edges", falls, n);
    if (muteAt > 0) check(muteDone && muteHeld, "R4 level held without ticks", int'(muteHeld), 1);
    parked = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (stepOut !== 1'b0) parked = 0;
    end
    check(parked, "R9 parked low after burst", int'(!parked), 0);
    runEn = 1'b0;
    @(negedge clk);
    check(stepOut === 1'b0, "R7 low after enable drop", int'(stepOut), 0);
  endtask

  // start a burst, drop enable after a number of ticks, check edges and abort
  task automatic abortAfter(input int n, input int d, input int ticks, input int expR, input int expF);
    int  k = 0;
    int  rises = 0;
    int  falls = 0;
    bit  t;
    logic prev = 1'b0;
    @(negedge clk);
    pulseCount = CW'(n);
    gapLen = DW'(d);
    runEn = 1'b1;
    @(negedge clk);
    while (k < ticks) begin
      t = tick;
      @(negedge clk);
      if (t) k++;
      if (stepOut && !prev) rises++;
      if (!stepOut && prev) falls++;
      prev = stepOut;
    end
    check(rises == expR, "R5 rising edges in window", rises, expR);
    check(falls == expF, "R5 falling edges in window", falls, expF);
    runEn = 1'b0;
    @(negedge clk);
    check(stepOut === 1'b0, "R7 abort low next clock", int'(stepOut), 0);
    for (int i = 0; i < 16; i++) @(negedge clk);
    check(stepOut === 1'b0, "R7 stays low after abort", int'(stepOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit quiet;
    // R1: reset holds output low while enabled and ticking
    @(negedge clk);
    runEn = 1'b1;
    pulseCount = 3'd3;
    gapLen = 3'd0;
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (stepOut !== 1'b0) quiet = 0;
    end
    check(quiet, "R1 low during reset", int'(!quiet), 0);
    runEn = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(stepOut === 1'b0, "R1 low after reset release", int'(stepOut), 0);

    for (int n = 0; n < (1 << CW); n++)
      for (int d = 0; d < (1 << DW); d++)
        runBurst(n, d, 1'b0, 0);

    tickPeriod = 1;
    runBurst(5, 1, 1'b0, 0);
    tickPeriod = 3;
    runBurst(3, 2, 1'b0, 0);
    tickPeriod = 4;

    runBurst(4, 2, 1'b1, 0);
    runBurst(2, 5, 1'b1, 0);
    runBurst(3, 1, 1'b0, 2);
    runBurst(2, 2, 1'b0, 4);

    abortAfter(7, 7, 35, 3, 2);
    abortAfter(5, 2, 2, 1, 0);
    abortAfter(6, 0, 5, 3, 2);

    // R1: asynchronous reset in the middle of a high phase
    @(negedge clk);
    pulseCount = 3'd7;
    gapLen = 3'd3;
    runEn = 1'b1;
    while (stepOut !== 1'b1) @(negedge clk);
    rst = 1'b1;
    #1;
    check(stepOut === 1'b0, "R1 asynchronous clear", int'(stepOut), 0);
    runEn = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(stepOut === 1'b0, "R1 low after mid-burst reset", int'(stepOut), 0);
    runBurst(2, 1, 1'b0, 0);

    summary();
    $finish;
  end

endmodule